// File: doc/BRIEF.md
# Hall-Commutated Three-Phase Spindle Controller

This block turns three digital Hall-sensor bits and a signed torque command into drive states for the U, V and W phases of a brushless spindle motor. Each phase is placed in one of three states: high-side source, low-side sink, or high impedance. A positive command spins the motor forward using a fixed six-step commutation table. A negative command brakes. The brake style is chosen by an input: either reverse torque, where the table has source and sink exchanged, or a short-circuit brake that grounds every phase.

While the reverse-torque style is active, a small sequence tracker watches the Hall code for backward steps. Once reverse rotation is seen under a negative command, all three phases are grounded until two forward steps in a row show that the rotor turns forward again. The sourcing phase is gated by a free-running PWM carrier whose period is derived from the system clock and a 100 kHz target, with the on-time set by a duty input. A frequency-generator pulse is synthesized from the Hall bits for speed measurement.

Top module: `spindle_commutator`

## Requirements
- R1: Phase state codes are 00 Hi-Z, 01 source, 10 sink. With drive enabled and a positive command, Hall code (U,V,W) gives {U,V,W} phases as follows: 001 → Hi-Z, source, sink; 011 → source, Hi-Z, sink; 010 → source, sink, Hi-Z; 110 → Hi-Z, sink, source; 100 → sink, Hi-Z, source; 101 → sink, source, Hi-Z.
- R2: With a negative command, brake_short low and no reverse rotation flagged, each Hall code gives the R1 pattern with source and sink exchanged, and Hi-Z phases stay Hi-Z.
- R3: With a negative command and brake_short high, all three phases are sink, whatever the Hall code is, including 000 and 111.
- R4: The forward Hall order is 001, 011, 010, 110, 100, 101, cyclic. A step from one valid code to the code that comes before it in this order flags reverse rotation. While the flag is set and the command is negative, all three phases are sink.
- R5: The reverse flag clears only after two consecutive forward steps. After one forward step, the phases are still all sink.
- R6: Hall codes 000 and 111 put all three phases in Hi-Z when the command is not negative, and also when the command is negative and no all-sink brake applies.
- R7: Driving drive_en low puts all three phases in Hi-Z at the first clock edge after it is sampled low, whatever the other inputs are.
- R8: A zero command puts all three phases in Hi-Z (coast).
- R9: The high-side gate of a phase is on only while that phase is in the source state and the PWM carrier is high. The carrier period is CLK_HZ/PWM_HZ cycles. In any window of one period, the carrier is high for min(duty, period) cycles, so a duty of 0 never turns it on.
- R10: The fg output equals the XOR of the three Hall bits sampled at the previous clock edge. It is 1 for Hall 100 and 0 for Hall 110.
- R11: After reset, all phases are Hi-Z, all gates are off and fg is 0.
- R12: Phase states and the fg output are registered: they change one clock edge after the inputs are sampled. The reverse flag takes one more edge to reach the phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_en | input | 1 | Global drive enable; low forces all phases Hi-Z |
| hall | input | 3 | Hall bits, bit 2 = U, bit 1 = V, bit 0 = W |
| torque_cmd | input | CMD_W | Signed torque command; sign selects drive or brake |
| brake_short | input | 1 | 1 selects the short-circuit brake, 0 selects the reverse-torque brake |
| duty | input | DUTY_W | PWM on-time in clock cycles per carrier period |
| ph_u | output | 2 | Phase U state (00 Hi-Z, 01 source, 10 sink) |
| ph_v | output | 2 | Phase V state |
| ph_w | output | 2 | Phase W state |
| hs_on | output | 3 | High-side gate per phase (bit 0 U, bit 1 V, bit 2 W), PWM-gated |
| ls_on | output | 3 | Low-side gate per phase (bit 0 U, bit 1 V, bit 2 W) |
| fg | output | 1 | Synthesized frequency-generator pulse |

## Verification
The bench targets the reverse-protect hysteresis. It takes one backward Hall step, then one forward step, and expects the phases to stay grounded; a design that cleared the flag after a single step would release the brake there. It also runs the short brake with invalid Hall codes: a design that checked Hall validity before the brake style would float the motor instead of grounding it. The PWM is measured over full carrier windows at duties of zero, mid-range, exactly one period and above one period, which exposes an off-by-one in the comparison or the wrap. The fg output is checked on every Hall code to catch an inverted or unregistered XOR.

// File: rtl/spin_pkg.sv
package spin_pkg;

    typedef enum logic [1:0] {
        PH_HIZ = 2'b00,
        PH_SRC = 2'b01,
        PH_SNK = 2'b10
    } ph_e;

    typedef struct packed {
        ph_e u;
        ph_e v;
        ph_e w;
    } drive_t;

    localparam int unsigned STEPS   = 6;
    localparam logic [2:0]  IDX_BAD = 3'd7;

    localparam drive_t ALL_HIZ = '{u: PH_HIZ, v: PH_HIZ, w: PH_HIZ};
    localparam drive_t ALL_SNK = '{u: PH_SNK, v: PH_SNK, w: PH_SNK};

    // Position of a Hall code in the forward sequence, IDX_BAD if invalid.
    function automatic logic [2:0] hall_idx(input logic [2:0] h);
        logic [2:0] r;
        case (h)
            3'b001:  r = 3'd0;
            3'b011:  r = 3'd1;
            3'b010:  r = 3'd2;
            3'b110:  r = 3'd3;
            3'b100:  r = 3'd4;
            3'b101:  r = 3'd5;
            default: r = IDX_BAD;
        endcase
        return r;
    endfunction

    function automatic logic [2:0] idx_next(input logic [2:0] i);
        return (i == 3'(STEPS - 1)) ? 3'd0 : i + 3'd1;
    endfunction

    function automatic logic [2:0] idx_prev(input logic [2:0] i);
        return (i == 3'd0) ? 3'(STEPS - 1) : i - 3'd1;
    endfunction

    // Forward six-step pattern.
    function automatic drive_t fwd_drive(input logic [2:0] i);
        drive_t r;
        case (i)
            3'd0:    r = '{u: PH_HIZ, v: PH_SRC, w: PH_SNK};
            3'd1:    r = '{u: PH_SRC, v: PH_HIZ, w: PH_SNK};
            3'd2:    r = '{u: PH_SRC, v: PH_SNK, w: PH_HIZ};
            3'd3:    r = '{u: PH_HIZ, v: PH_SNK, w: PH_SRC};
            3'd4:    r = '{u: PH_SNK, v: PH_HIZ, w: PH_SRC};
            3'd5:    r = '{u: PH_SNK, v: PH_SRC, w: PH_HIZ};
            default: r = ALL_HIZ;
        endcase
        return r;
    endfunction

    function automatic ph_e swap_ph(input ph_e p);
        ph_e r;
        case (p)
            PH_SRC:  r = PH_SNK;
            PH_SNK:  r = PH_SRC;
            default: r = PH_HIZ;
        endcase
        return r;
    endfunction

    function automatic drive_t swap_drive(input drive_t d);
        drive_t r;
        r.u = swap_ph(d.u);
        r.v = swap_ph(d.v);
        r.w = swap_ph(d.w);
        return r;
    endfunction

endpackage

// File: rtl/spin_pwm.sv
module spin_pwm #(
    parameter int unsigned PERIOD = 1250,
    parameter int unsigned DUTY_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm
);

    localparam logic [DUTY_W-1:0] LAST = DUTY_W'(PERIOD - 1);

    typedef struct packed {
        logic [DUTY_W-1:0] cnt;
        logic              pwm;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + DUTY_W'(1);
        st_d.pwm = (st_q.cnt < duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm = st_q.pwm;

    // R9: the carrier counter never leaves its period
    p_cnt_in_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R9: zero duty keeps the carrier low
    p_zero_duty_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |=> !st_q.pwm);

endmodule

// File: rtl/spin_dirdet.sv
module spin_dirdet #(
    parameter int unsigned FWD_CLEAR = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall,
    output logic       rev,
    output logic       fg
);
    import spin_pkg::*;

    localparam int unsigned CW = $clog2(FWD_CLEAR + 1);

    typedef struct packed {
        logic [2:0]    last;
        logic          last_vld;
        logic          rev;
        logic [CW-1:0] fwd;
        logic          fg;
    } st_t;

    st_t st_d, st_q;

    logic [2:0] idx;
    logic       vld;
    logic       moved;
    logic       step_fwd;
    logic       step_back;

    always_comb begin
        idx       = hall_idx(hall);
        vld       = (idx != IDX_BAD);
        moved     = vld && st_q.last_vld && (idx != st_q.last);
        step_fwd  = moved && (idx == idx_next(st_q.last));
        step_back = moved && (idx == idx_prev(st_q.last));

        st_d    = st_q;
        st_d.fg = ^hall;
        if (vld) begin
            st_d.last     = idx;
            st_d.last_vld = 1'b1;
        end
        if (step_back) begin
            st_d.rev = 1'b1;
            st_d.fwd = '0;
        end else if (step_fwd && st_q.rev) begin
            if (st_q.fwd == CW'(FWD_CLEAR - 1)) begin
                st_d.rev = 1'b0;
                st_d.fwd = '0;
            end else begin
                st_d.fwd = st_q.fwd + CW'(1);
            end
        end else if (moved && !step_fwd) begin
            st_d.fwd = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rev = st_q.rev;
    assign fg  = st_q.fg;

    // R4: a backward step from a known position raises the flag
    p_back_sets_rev_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_back |=> st_q.rev);

    // R5: a set flag never drops without a forward step
    p_rev_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rev && !step_fwd) |=> st_q.rev);

    // R10: fg follows the parity of the previously sampled Hall bits
    p_fg_parity_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (st_q.fg == $past(^hall)));

endmodule

// File: rtl/spin_commut.sv
module spin_commut #(
    parameter int unsigned CMD_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    drive_en,
    input  logic [2:0]              hall,
    input  logic signed [CMD_W-1:0] torque_cmd,
    input  logic                    brake_short,
    input  logic                    rev,
    output spin_pkg::drive_t        drv
);
    import spin_pkg::*;

    typedef struct packed {
        drive_t drv;
    } st_t;

    st_t st_d, st_q;

    logic [2:0] idx;
    logic       cmd_neg;
    logic       cmd_zero;

    always_comb begin
        idx      = hall_idx(hall);
        cmd_neg  = torque_cmd[CMD_W-1];
        cmd_zero = (torque_cmd == '0);

        st_d = st_q;
        if (!drive_en) begin
            st_d.drv = ALL_HIZ;
        end else if (cmd_neg && (brake_short || rev)) begin
            st_d.drv = ALL_SNK;
        end else if (cmd_zero || idx == IDX_BAD) begin
            st_d.drv = ALL_HIZ;
        end else if (cmd_neg) begin
            st_d.drv = swap_drive(fwd_drive(idx));
        end else begin
            st_d.drv = fwd_drive(idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.drv <= ALL_HIZ;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv = st_q.drv;

    // R7: disable floats every phase one edge later
    p_disable_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |=> (st_q.drv == ALL_HIZ));

    // R3: short brake grounds all phases
    p_short_sink_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && torque_cmd[CMD_W-1] && brake_short) |=> (st_q.drv == ALL_SNK));

    // R4: reverse protect grounds all phases
    p_protect_sink_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && torque_cmd[CMD_W-1] && rev) |=> (st_q.drv == ALL_SNK));

    // R6: invalid Hall codes float the motor when no brake applies
    p_invalid_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!torque_cmd[CMD_W-1] && (hall == 3'b000 || hall == 3'b111)) |=> (st_q.drv == ALL_HIZ));

    // R1: at most one phase sources at any time
    p_one_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({st_q.drv.u == PH_SRC, st_q.drv.v == PH_SRC, st_q.drv.w == PH_SRC}) <= 1);

endmodule

// File: rtl/spindle_commutator.sv
module spindle_commutator #(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned PWM_HZ    = 100_000,
    parameter int unsigned CMD_W     = 12,
    parameter int unsigned FWD_CLEAR = 2,
    localparam int unsigned PERIOD   = CLK_HZ / PWM_HZ,
    localparam int unsigned DUTY_W   = $clog2(PERIOD + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    drive_en,
    input  logic [2:0]              hall,
    input  logic signed [CMD_W-1:0] torque_cmd,
    input  logic                    brake_short,
    input  logic [DUTY_W-1:0]       duty,
    output logic [1:0]              ph_u,
    output logic [1:0]              ph_v,
    output logic [1:0]              ph_w,
    output logic [2:0]              hs_on,
    output logic [2:0]              ls_on,
    output logic                    fg
);
    import spin_pkg::*;

    drive_t drv;
    logic   rev;
    logic   pwm;
    ph_e    ph_arr [3];

    spin_dirdet #(.FWD_CLEAR(FWD_CLEAR)) u_dirdet (
        .clk  (clk),
        .rst_n(rst_n),
        .hall (hall),
        .rev  (rev),
        .fg   (fg)
    );

    spin_pwm #(.PERIOD(PERIOD), .DUTY_W(DUTY_W)) u_pwm (
        .clk  (clk),
        .rst_n(rst_n),
        .duty (duty),
        .pwm  (pwm)
    );

    spin_commut #(.CMD_W(CMD_W)) u_commut (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_en   (drive_en),
        .hall       (hall),
        .torque_cmd (torque_cmd),
        .brake_short(brake_short),
        .rev        (rev),
        .drv        (drv)
    );

    assign ph_arr[0] = drv.u;
    assign ph_arr[1] = drv.v;
    assign ph_arr[2] = drv.w;

    assign ph_u = drv.u;
    assign ph_v = drv.v;
    assign ph_w = drv.w;

    for (genvar i = 0; i < 3; i++) begin : g_gate
        assign hs_on[i] = (ph_arr[i] == PH_SRC) && pwm;
        assign ls_on[i] = (ph_arr[i] == PH_SNK);

        // R9: the two switches of a leg are never on together
        p_no_shoot_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(hs_on[i] && ls_on[i]));
    end

endmodule

// File: tb/tb_spindle_commutator.sv
module tb_spindle_commutator;

    localparam int PERIOD = 1250;
    localparam int DW     = 11;
    localparam int CW     = 12;

    localparam logic [1:0] Z = 2'b00;
    localparam logic [1:0] S = 2'b01;
    localparam logic [1:0] K = 2'b10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 drive_en = 1'b0;
    logic [2:0]           hall = 3'b000;
    logic signed [CW-1:0] torque_cmd = '0;
    logic                 brake_short = 1'b0;
    logic [DW-1:0]        duty = '0;
    logic [1:0]           ph_u, ph_v, ph_w;
    logic [2:0]           hs_on, ls_on;
    logic                 fg;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spindle_commutator dut (
        .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .hall(hall),
        .torque_cmd(torque_cmd), .brake_short(brake_short), .duty(duty),
        .ph_u(ph_u), .ph_v(ph_v), .ph_w(ph_w),
        .hs_on(hs_on), .ls_on(ls_on), .fg(fg)
    );

    function automatic logic [5:0] exp_fwd(input logic [2:0] h);
        case (h)
            3'b001:  return {Z, S, K};
            3'b011:  return {S, Z, K};
            3'b010:  return {S, K, Z};
            3'b110:  return {Z, K, S};
            3'b100:  return {K, Z, S};
            3'b101:  return {K, S, Z};
            default: return {Z, Z, Z};
        endcase
    endfunction

    function automatic logic [5:0] exp_swap(input logic [5:0] p);
        logic [5:0] r;
        for (int i = 0; i < 3; i++) begin
            case (p[i*2 +: 2])
                S:       r[i*2 +: 2] = K;
                K:       r[i*2 +: 2] = S;
                default: r[i*2 +: 2] = Z;
            endcase
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic en, input logic [2:0] h,
                         input logic signed [CW-1:0] c, input logic sb);
        @(negedge clk);
        drive_en = en; hall = h; torque_cmd = c; brake_short = sb;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        drive_en = 1'b0; hall = 3'b000; torque_cmd = '0; brake_short = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 phases", {ph_u, ph_v, ph_w}, {Z, Z, Z});
        chk("R11 gates", {hs_on, ls_on}, 6'b0);
        chk("R11 fg", fg, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_forward;
        logic [2:0] seq [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
        do_reset();
        duty = DW'(PERIOD);
        for (int i = 0; i < 6; i++) begin
            apply(1'b1, seq[i], 12'sd100, 1'b0);
            chk($sformatf("R1 hall %b", seq[i]), {ph_u, ph_v, ph_w}, exp_fwd(seq[i]));
        end
    endtask

    task automatic t_rev_torque;
        logic [2:0] seq [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
        do_reset();
        for (int i = 0; i < 6; i++) begin
            apply(1'b1, seq[i], -12'sd100, 1'b0);
            chk($sformatf("R2 hall %b", seq[i]), {ph_u, ph_v, ph_w}, exp_swap(exp_fwd(seq[i])));
        end
    endtask

    task automatic t_short;
        logic [2:0] hs [3] = '{3'b010, 3'b000, 3'b111};
        for (int i = 0; i < 3; i++) begin
            apply(1'b1, hs[i], -12'sd100, 1'b1);
            chk($sformatf("R3 hall %b", hs[i]), {ph_u, ph_v, ph_w}, {K, K, K});
        end
    endtask

    task automatic t_protect;
        do_reset();
        apply(1'b1, 3'b001, -12'sd100, 1'b0);
        chk("R2 pre-protect 001", {ph_u, ph_v, ph_w}, {Z, K, S});
        apply(1'b1, 3'b101, -12'sd100, 1'b0);
        chk("R4 backward step grounds", {ph_u, ph_v, ph_w}, {K, K, K});
        chk("R4 low gates", ls_on, 3'b111);
        apply(1'b1, 3'b001, -12'sd100, 1'b0);
        chk("R5 one forward step holds", {ph_u, ph_v, ph_w}, {K, K, K});
        apply(1'b1, 3'b011, -12'sd100, 1'b0);
        chk("R5 two forward steps release", {ph_u, ph_v, ph_w}, {K, Z, S});
    endtask

    task automatic t_invalid;
        do_reset();
        apply(1'b1, 3'b000, 12'sd100, 1'b0);
        chk("R6 hall 000", {ph_u, ph_v, ph_w}, {Z, Z, Z});
        apply(1'b1, 3'b111, 12'sd100, 1'b0);
        chk("R6 hall 111", {ph_u, ph_v, ph_w}, {Z, Z, Z});
        apply(1'b1, 3'b111, -12'sd100, 1'b0);
        chk("R6 hall 111 negative", {ph_u, ph_v, ph_w}, {Z, Z, Z});
    endtask

    task automatic t_disable;
        apply(1'b1, 3'b011, 12'sd100, 1'b0);
        chk("R1 before disable", {ph_u, ph_v, ph_w}, {S, Z, K});
        @(negedge clk);
        drive_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R7 one edge after disable", {ph_u, ph_v, ph_w}, {Z, Z, Z});
        chk("R7 gates off", {hs_on, ls_on}, 6'b0);
        apply(1'b0, 3'b010, -12'sd100, 1'b1);
        chk("R7 disable beats short brake", {ph_u, ph_v, ph_w}, {Z, Z, Z});
    endtask

    task automatic t_coast;
        apply(1'b1, 3'b110, 12'sd0, 1'b1);
        chk("R8 zero command", {ph_u, ph_v, ph_w}, {Z, Z, Z});
    endtask

    task automatic t_pwm;
        int duties [4] = '{0, 300, PERIOD, 2000};
        int cnt;
        int exp;
        apply(1'b1, 3'b011, 12'sd100, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            duty = DW'(duties[i]);
            repeat (4) @(negedge clk);
            cnt = 0;
            for (int k = 0; k < PERIOD; k++) begin
                @(negedge clk);
                if (hs_on[0]) cnt++;
                if (hs_on[1] || hs_on[2]) cnt += 10000;
            end
            exp = (duties[i] > PERIOD) ? PERIOD : duties[i];
            chk($sformatf("R9 duty %0d on-cycles", duties[i]), cnt, exp);
        end
        chk("R9 sink gate steady", ls_on, 3'b100);
    endtask

    task automatic t_fg;
        for (int h = 0; h < 8; h++) begin
            @(negedge clk);
            hall = 3'(h);
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R10 R12 fg hall %b", 3'(h)), fg, ^(3'(h)));
        end
        @(negedge clk);
        hall = 3'b100;
        @(negedge clk);
        chk("R12 fg not yet updated", fg, 1'b1);
        hall = 3'b110;
        @(posedge clk);
        @(negedge clk);
        chk("R10 fg hall 110", fg, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_forward();
        t_rev_torque();
        t_short();
        t_protect();
        t_invalid();
        t_disable();
        t_coast();
        t_pwm();
        t_fg();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule